// File: doc/BRIEF.md
# Mailbox Outbound Request Dispatcher

This block is the transmit side of a host-to-coprocessor mailbox. The host writes 32-bit request words into a small write window. The low four bits of each word select a target channel. If that channel is idle and nothing is already queued, the word goes straight out on the channel strobe in the next cycle. If the channel reports a pending request, or if earlier words are still waiting, the word is parked in a deferral FIFO. The FIFO then drains in strict order. Its head is released only when the head's own channel drops its busy flag, and while the head is blocked, every entry behind it waits too.

The host can read two words. One is a queue status word with full and empty flags and the fill level. The other is an error word with two sticky flags: one for writes dropped because the queue was full, and one for words aimed at a channel that does not exist. Any write to the error word's offset clears both flags.

A small level state machine tracks the queue: EMPTY, QUEUED or FULL. A word can bypass the queue only in EMPTY. A new word is refused only in FULL. The transitions are:
- EMPTY to QUEUED on a push.
- QUEUED to FULL when a push without a pop fills the last slot.
- QUEUED to EMPTY when a pop without a push takes the last entry.
- FULL to QUEUED on a pop.

Top module: `mbtx_dispatch`

## Requirements
- R1: A write whose offset lies from 0xA0 to 0xAC inclusive submits the write data as a request. Writes to any other offset submit nothing.
- R2: The channel tag is data bits [3:0]. When the tagged channel's busy input is low and the queue is empty, the word appears one cycle later on `chan_data`, with `chan_valid` set only at that channel's bit.
- R3: A request whose tag is 9 or more (with the default 9 channels) is discarded and sets the sticky invalid-channel flag, bit 11 of the error word.
- R4: A request is queued instead of forwarded when its channel is busy, or when the queue already holds any entry, even if the target channel is idle.
- R5: In any cycle where the queue head's channel is not busy, the head is popped and forwarded one cycle later. Entries leave in arrival order, and a blocked head holds back all entries behind it.
- R6: A request that arrives while the queue holds 8 entries is dropped and sets the sticky overflow flag, bit 9 of the error word. The full check takes precedence over the tag check.
- R7: Reading offset 0xB8 returns the queue status: bit 31 full, bit 30 empty, bits [7:0] the entry count, all other bits zero.
- R8: Reading offset 0x9C returns the error word. Any write to 0x9C clears both error flags. Reads of any other offset return zero.
- R9: After reset the queue is empty, no channel strobe is active, and both error flags are clear.
- R10: At most one bit of `chan_valid` is set in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 8 | Host write offset |
| wr_data | input | 32 | Host write data |
| rd_addr | input | 8 | Host read offset (read data is combinational) |
| rd_data | output | 32 | Host read data |
| chan_busy | input | NCH | Per-channel pending flag |
| chan_valid | output | NCH | One-hot channel delivery strobe |
| chan_data | output | 32 | Word delivered to the strobed channel |

## Verification
The bench covers several failure cases:
- An idle channel written while an older word for a busy channel is still queued. A design that forwards it directly would reorder traffic.
- A blocked head with an idle channel behind it. A design that skips the head would break FIFO order.
- Eight queued words drained after release, checked word by word for order. A design that lost the order would fail here.
- A ninth write that carries an invalid tag. A design that checks the tag before fullness would set the wrong error bit.
- Writes just outside the window. A design with a loose window decode would accept them.
- Clearing the sticky flags through the config offset. A design that does not clear them would leave errors latched.

// File: rtl/mbtx_pkg.sv
package mbtx_pkg;
    localparam int WORD_W = 32;

    localparam logic [7:0] OFS_WIN_LO = 8'hA0;
    localparam logic [7:0] OFS_WIN_HI = 8'hAC;
    localparam logic [7:0] OFS_QSTAT  = 8'hB8;
    localparam logic [7:0] OFS_ERRCFG = 8'h9C;

    localparam int BIT_FULL  = 31;
    localparam int BIT_EMPTY = 30;
    localparam int BIT_OVF   = 9;
    localparam int BIT_INV   = 11;

    typedef enum logic [1:0] {
        ST_EMPTY  = 2'd0,
        ST_QUEUED = 2'd1,
        ST_FULL   = 2'd2
    } lvl_e;
endpackage

// File: rtl/mbtx_fifo.sv
module mbtx_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 32,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count
);
    localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] CNT_MAX  = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;

    assign head = mem[rp];

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) wp <= (wp == PTR_LAST) ? '0 : wp + 1'b1;
            if (pop)  rp <= (rp == PTR_LAST) ? '0 : rp + 1'b1;
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R6: the controller never pushes into a full queue
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count != CNT_MAX));
    // R5: the controller never pops an empty queue
    p_pop_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));
endmodule

// File: rtl/mbtx_ctrl.sv
module mbtx_ctrl
    import mbtx_pkg::*;
#(
    parameter int NCH   = 9,
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              cfg_wr,
    input  logic [NCH-1:0]    busy,
    input  logic [CW-1:0]     fifo_count,
    input  logic [WORD_W-1:0] fifo_head,
    output logic              push,
    output logic              pop,
    output logic              q_empty,
    output logic              q_full,
    output logic [NCH-1:0]    chan_valid,
    output logic [WORD_W-1:0] chan_data,
    output logic              err_ovf,
    output logic              err_inval
);
    localparam logic [CW-1:0] CNT_LAST = CW'(DEPTH - 1);
    localparam logic [CW-1:0] CNT_MAX  = CW'(DEPTH);
    localparam logic [4:0]    NCH_T    = 5'(NCH);

    lvl_e state, state_nx;

    logic [3:0]  tag, head_tag;
    logic [15:0] busy_w, oh_new, oh_head;
    logic        tag_ok, accept, do_direct, drop_ovf, drop_inv;

    assign tag      = wr_data[3:0];
    assign head_tag = fifo_head[3:0];
    assign busy_w   = 16'(busy);
    assign oh_new   = 16'd1 << tag;
    assign oh_head  = 16'd1 << head_tag;
    assign tag_ok   = {1'b0, tag} < NCH_T;

    assign q_empty   = (state == ST_EMPTY);
    assign q_full    = (state == ST_FULL);
    assign drop_ovf  = wr_hit && q_full;
    assign drop_inv  = wr_hit && !q_full && !tag_ok;
    assign accept    = wr_hit && !q_full && tag_ok;
    assign do_direct = accept && q_empty && !busy_w[tag];
    assign push      = accept && !do_direct;
    assign pop       = !q_empty && !busy_w[head_tag];

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_EMPTY:  if (push) state_nx = (DEPTH == 1) ? ST_FULL : ST_QUEUED;
            ST_QUEUED: begin
                if (push && !pop && fifo_count == CNT_LAST)
                    state_nx = ST_FULL;
                else if (pop && !push && fifo_count == CW'(1))
                    state_nx = ST_EMPTY;
            end
            ST_FULL:   if (pop) state_nx = (DEPTH == 1) ? ST_EMPTY : ST_QUEUED;
            default:   state_nx = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_valid <= '0;
            chan_data  <= '0;
            err_ovf    <= 1'b0;
            err_inval  <= 1'b0;
        end else begin
            if (do_direct) begin
                chan_valid <= oh_new[NCH-1:0];
                chan_data  <= wr_data;
            end else if (pop) begin
                chan_valid <= oh_head[NCH-1:0];
                chan_data  <= fifo_head;
            end else begin
                chan_valid <= '0;
            end
            err_ovf   <= cfg_wr ? 1'b0 : (err_ovf   | drop_ovf);
            err_inval <= cfg_wr ? 1'b0 : (err_inval | drop_inv);
        end
    end

    // R10: one channel strobe at most
    p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chan_valid));
    // R5: a word is delivered only to a channel that was idle when it left
    p_idle_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|chan_valid) |-> ((chan_valid & $past(busy)) == '0));
    // R7: level state agrees with the storage count
    p_level_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q_empty == (fifo_count == '0)) && (q_full == (fifo_count == CNT_MAX)));
    // R3: invalid-channel flag holds until a config write
    p_err_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(err_inval) && !$past(cfg_wr)) |-> err_inval);
endmodule

// File: rtl/mbtx_dispatch.sv
module mbtx_dispatch
    import mbtx_pkg::*;
#(
    parameter int NCH   = 9,
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [7:0]        rd_addr,
    output logic [WORD_W-1:0] rd_data,
    input  logic [NCH-1:0]    chan_busy,
    output logic [NCH-1:0]    chan_valid,
    output logic [WORD_W-1:0] chan_data
);
    localparam int CW = $clog2(DEPTH + 1);

    logic              wr_hit, cfg_wr, push, pop, q_empty, q_full, err_ovf, err_inval;
    logic [CW-1:0]     count;
    logic [WORD_W-1:0] head;

    assign wr_hit = wr_en && (wr_addr >= OFS_WIN_LO) && (wr_addr <= OFS_WIN_HI);
    assign cfg_wr = wr_en && (wr_addr == OFS_ERRCFG);

    mbtx_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .din   (wr_data),
        .head  (head),
        .count (count)
    );

    mbtx_ctrl #(.NCH(NCH), .DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_hit     (wr_hit),
        .wr_data    (wr_data),
        .cfg_wr     (cfg_wr),
        .busy       (chan_busy),
        .fifo_count (count),
        .fifo_head  (head),
        .push       (push),
        .pop        (pop),
        .q_empty    (q_empty),
        .q_full     (q_full),
        .chan_valid (chan_valid),
        .chan_data  (chan_data),
        .err_ovf    (err_ovf),
        .err_inval  (err_inval)
    );

    always_comb begin
        rd_data = '0;
        if (rd_addr == OFS_QSTAT) begin
            rd_data[BIT_FULL]  = q_full;
            rd_data[BIT_EMPTY] = q_empty;
            rd_data[7:0]       = 8'(count);
        end else if (rd_addr == OFS_ERRCFG) begin
            rd_data[BIT_OVF] = err_ovf;
            rd_data[BIT_INV] = err_inval;
        end
    end
endmodule

// File: tb/mbtx_dispatch_test.sv
module mbtx_dispatch_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = 8'h00;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = 8'h00;
    logic [31:0] rd_data;
    logic [8:0]  chan_busy = '0;
    logic [8:0]  chan_valid;
    logic [31:0] chan_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mbtx_dispatch #(.NCH(9), .DEPTH(8)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .chan_busy(chan_busy), .chan_valid(chan_valid), .chan_data(chan_data)
    );

    typedef struct packed {
        logic        wr;
        logic [8:0]  busy;
        logic [31:0] data;
        logic [8:0]  ev;
        logic [31:0] ed;
        logic [7:0]  ecnt;
        logic [31:0] eerr;
    } vec_t;

    localparam vec_t TBL [7] = '{
        '{1'b1, 9'h000, 32'h12345672, 9'h004, 32'h12345672, 8'd0, 32'h0},
        '{1'b1, 9'h020, 32'hAAAA0005, 9'h000, 32'h0,        8'd1, 32'h0},
        '{1'b1, 9'h020, 32'h00000101, 9'h000, 32'h0,        8'd2, 32'h0},
        '{1'b0, 9'h000, 32'h0,        9'h020, 32'hAAAA0005, 8'd1, 32'h0},
        '{1'b0, 9'h000, 32'h0,        9'h002, 32'h00000101, 8'd0, 32'h0},
        '{1'b1, 9'h000, 32'h00000088, 9'h100, 32'h00000088, 8'd0, 32'h0},
        '{1'b1, 9'h000, 32'h00000009, 9'h000, 32'h0,        8'd0, 32'h800}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) step();
        // R9: reset state
        rd(8'hB8, v); chk("R9 status after reset", v, 32'h4000_0000);
        rd(8'h9C, v); chk("R9 errors after reset", v, 32'h0);
        chk("R9 no strobe", 32'(chan_valid), 32'h0);
        rst_n = 1'b1;
        step();

        // Table walk: R2, R4, R5, R3
        for (int i = 0; i < 7; i++) begin
            chan_busy = TBL[i].busy;
            wr_en     = TBL[i].wr;
            wr_addr   = 8'hA0 + 8'(4 * (i % 4));
            wr_data   = TBL[i].data;
            step();
            wr_en = 1'b0;
            chk("R2/R4/R5 strobe", 32'(chan_valid), 32'(TBL[i].ev));
            if (TBL[i].ev != 0) chk("R2/R5 data", chan_data, TBL[i].ed);
            rd(8'hB8, v); chk("R4/R7 count", {24'h0, v[7:0]}, 32'(TBL[i].ecnt));
            rd(8'h9C, v); chk("R3 error word", v, TBL[i].eerr);
        end

        // R8: config write clears sticky flags
        wr_en = 1'b1; wr_addr = 8'h9C; wr_data = 32'h0;
        step(); wr_en = 1'b0;
        rd(8'h9C, v); chk("R8 errors cleared", v, 32'h0);
        rd(8'h80, v); chk("R8 other offset reads zero", v, 32'h0);

        // R1: writes just outside the window are ignored
        wr_en = 1'b1; wr_addr = 8'hB0; wr_data = 32'h00000000;
        step();
        chk("R1 above window no strobe", 32'(chan_valid), 32'h0);
        wr_addr = 8'h9F; wr_data = 32'h00000001;
        step(); wr_en = 1'b0;
        chk("R1 below window no strobe", 32'(chan_valid), 32'h0);
        rd(8'hB8, v); chk("R1 queue untouched", v, 32'h4000_0000);

        // R6: fill queue behind busy channel 3
        chan_busy = 9'h008;
        for (int i = 0; i < 8; i++) begin
            wr_en = 1'b1; wr_addr = 8'hA0 + 8'(4 * (i % 4));
            wr_data = 32'h100 * i + 32'h3;
            step();
            chk("R4 queued no strobe", 32'(chan_valid), 32'h0);
        end
        rd(8'hB8, v); chk("R7 full status", v, 32'h8000_0008);
        wr_data = 32'h0000000C; // invalid tag while full
        step(); wr_en = 1'b0;
        rd(8'h9C, v); chk("R6 overflow wins over tag", v, 32'h200);
        rd(8'hB8, v); chk("R6 still full", v, 32'h8000_0008);

        // R5: drain in order
        chan_busy = 9'h000;
        for (int i = 0; i < 8; i++) begin
            step();
            chk("R5 drain strobe", 32'(chan_valid), 32'h8);
            chk("R5 drain order", chan_data, 32'h100 * i + 32'h3);
        end
        step();
        chk("R5 idle after drain", 32'(chan_valid), 32'h0);
        rd(8'hB8, v); chk("R7 empty after drain", v, 32'h4000_0000);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule